// File: doc/BRIEF.md
# Register-File LIFO Stack with Wrapping Pointer

This block is a last-in, first-out store built from a bank of registers. It is addressed by a stack pointer that counts modulo the depth. A push advances the pointer first and then writes the incoming word at the new pointer value. A pop copies the word at the current pointer into an output data register and then moves the pointer back by one. The default depth is 64 words, so the pointer is 6 bits wide. The first item pushed therefore lands in word 1, and the item that fills the stack lands in word 0.

The block has no occupancy counter. Two one-bit flags, `full_o` and `empty_o`, are updated only when the pointer lands on zero:
- A push that leaves the pointer at zero sets `full_o`.
- A pop that leaves the pointer at zero sets `empty_o`.
- Every legal push clears `empty_o`, and every legal pop clears `full_o`.

The following requests are rejected and leave every register as it was:
- a push while full,
- a pop while empty,
- a push and a pop asserted in the same cycle.

For each rejected request, `err_o` is high for exactly one cycle.

Each accepted request completes in one clock edge. The output data register keeps the last popped word until the next legal pop.

Top module: `reg_stack`

## Requirements
- R1: After a synchronous active-low reset, `sp_o` is 0, `empty_o` is 1, `full_o` is 0, `err_o` is 0 and `dout_o` is 0.
- R2: A legal push (`push_i`=1, `pop_i`=0, `full_o`=0) raises `sp_o` by one modulo 64 at the next edge and clears `empty_o`.
- R3: The first item pushed onto an empty stack is stored at word 1. Popping it right away returns it, brings `sp_o` back to 0 and sets `empty_o`.
- R4: After 64 pushes from empty, `sp_o` is 0 and `full_o` is 1. `full_o` stays 0 after each of the first 63 pushes.
- R5: A legal pop (`pop_i`=1, `push_i`=0, `empty_o`=0) loads `dout_o` with the word at the current `sp_o`, lowers `sp_o` by one modulo 64 and clears `full_o`. From full, the first pop returns the 64th item.
- R6: `empty_o` is set exactly when a legal pop leaves `sp_o` at 0; otherwise a pop leaves it at 0.
- R7: A push while `full_o`=1 is ignored. `sp_o`, the flags, the stored words and `dout_o` are unchanged, and `err_o` is 1 in the following cycle.
- R8: A pop while `empty_o`=1 is ignored. `sp_o`, the flags and `dout_o` are unchanged, and `err_o` is 1 in the following cycle.
- R9: `push_i` and `pop_i` high together is ignored with no state change, and `err_o` is 1 in the following cycle.
- R10: Words come back in the reverse of the order in which they were pushed, including across interleaved pushes and pops.
- R11: `dout_o` keeps its value through idle cycles and pushes until the next legal pop.
- R12: `err_o` is a single-cycle pulse. It is 0 after any idle cycle or legal operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| din_i | input | DATA_W | Word to push |
| dout_o | output | DATA_W | Output data register holding the last popped word |
| sp_o | output | ADDR_W | Stack pointer, addressing the top word |
| full_o | output | 1 | Stack holds all 64 words |
| empty_o | output | 1 | Stack holds no words |
| err_o | output | 1 | One-cycle pulse after a rejected request |

## Verification
The properties assume that `push_i` and `pop_i` are settled levels sampled once per rising edge. They also assume that a request is never qualified by anything other than the flags visible in the same cycle. This is why a push and a pop together are treated as one rejected request rather than two.

The stimulus changes inputs only on falling edges, and it holds each request for exactly one edge. The sequence is:
1. a full fill to 64 words, checked after every edge,
2. rejected pushes at full,
3. a full drain, checked after every edge,
4. rejected pops at empty,
5. simultaneous requests in both the empty and the partly filled state,
6. an interleaved pattern that wraps the pointer several times.

Every push word comes from an arithmetic sequence, so each pop result is predictable from the push order alone.

// File: rtl/reg_stack_pkg.sv
// Package: shared types for the register stack.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package reg_stack_pkg;
    // Decoded request class for one clock cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_BAD  = 2'd3
    } stk_op_e;
endpackage

// File: rtl/stack_ctrl.sv
// Module: stack_ctrl
// Decodes push/pop requests against the flags and owns the stack pointer,
// the full/empty flags and the error pulse. It produces the write address
// (pointer plus one) and the read address (current pointer) for storage.
// Assumes: requests are sampled once per rising edge; reset is synchronous.
module stack_ctrl
    import reg_stack_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    output stk_op_e           op_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);
    localparam logic [ADDR_W-1:0] PTR_ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PTR_ZERO = '0;

    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] sp_up;
    logic [ADDR_W-1:0] sp_dn;
    logic              full_q;
    logic              empty_q;
    logic              err_q;
    stk_op_e           op;

    // Wrapping neighbours of the pointer
    always_comb begin
        sp_up = sp_q + PTR_ONE;
        sp_dn = sp_q - PTR_ONE;
    end

    // Classify the request; collisions and illegal states become OP_BAD
    always_comb begin
        if (push_i && pop_i)  op = OP_BAD;
        else if (push_i)      op = full_q  ? OP_BAD : OP_PUSH;
        else if (pop_i)       op = empty_q ? OP_BAD : OP_POP;
        else                  op = OP_IDLE;
    end

    // Pointer and flag update, one operation per edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q    <= PTR_ZERO;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            case (op)
                OP_PUSH: begin
                    sp_q    <= sp_up;
                    full_q  <= (sp_up == PTR_ZERO);
                    empty_q <= 1'b0;
                end
                OP_POP: begin
                    sp_q    <= sp_dn;
                    empty_q <= (sp_dn == PTR_ZERO);
                    full_q  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Registered one-cycle error pulse for a rejected request
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (op == OP_BAD);
    end

    assign op_o      = op;
    assign wr_addr_o = sp_up;
    assign rd_addr_o = sp_q;
    assign sp_o      = sp_q;
    assign full_o    = full_q;
    assign empty_o   = empty_q;
    assign err_o     = err_q;
endmodule

// File: rtl/stack_store.sv
// Module: stack_store
// Register bank of 2**ADDR_W words with one write port and one read port.
// The read port feeds an output data register loaded on a pop.
// Assumes: the write and read enables are mutually exclusive (the control
// guarantees this). The words themselves are not reset; only the output
// data register is.
module stack_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] dr_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_q [DEPTH];
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] dr_q;

    // One register per word, each with its own decoded write enable
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Capture the incoming word when this address is written
        always_ff @(posedge clk) begin
            if (we_i && (waddr_i == ADDR_W'(g))) word_q[g] <= wdata_i;
        end
    end

    // Read multiplexer on the current top
    always_comb rd_word = word_q[raddr_i];

    // Output data register: loads on a pop, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    dr_q <= '0;
        else if (re_i) dr_q <= rd_word;
    end

    assign dr_o = dr_q;
endmodule

// File: rtl/reg_stack.sv
// Module: reg_stack (top)
// Register-file LIFO with a wrapping pointer and full/empty flags set on
// landing at pointer zero. Rejected requests pulse err_o for one cycle.
// Assumes: a single clock domain and a synchronous active-low reset.
module reg_stack
    import reg_stack_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);
    stk_op_e           op;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    stack_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .op_o      (op),
        .wr_addr_o (wr_addr),
        .rd_addr_o (rd_addr),
        .sp_o      (sp_o),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .err_o     (err_o)
    );

    stack_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (op == OP_PUSH),
        .waddr_i (wr_addr),
        .wdata_i (din_i),
        .re_i    (op == OP_POP),
        .raddr_i (rd_addr),
        .dr_o    (dout_o)
    );
endmodule

// File: rtl/reg_stack_chk.sv
// Module: reg_stack_chk
// Port-level properties for reg_stack, attached with bind below.
// Assumes: requests are sampled on rising edges with synchronous reset.
module reg_stack_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic [DATA_W-1:0] dout_o,
    input logic [ADDR_W-1:0] sp_o,
    input logic              full_o,
    input logic              empty_o,
    input logic              err_o
);
    logic [ADDR_W-1:0] sp_inc;
    logic [ADDR_W-1:0] sp_dec;
    logic              good_push;
    logic              good_pop;

    // Expected neighbours and legal-request qualifiers
    always_comb begin
        sp_inc    = sp_o + ADDR_W'(1);
        sp_dec    = sp_o - ADDR_W'(1);
        good_push = push_i && !pop_i && !full_o;
        good_pop  = pop_i && !push_i && !empty_o;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sp_o == '0) && empty_o && !full_o && !err_o);

    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        good_push |=> (sp_o == $past(sp_inc)) && !empty_o);

    p_full_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        good_push && (sp_inc == '0) |=> full_o);

    p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        good_pop |=> (sp_o == $past(sp_dec)) && !full_o);

    p_empty_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        good_pop |=> (empty_o == (sp_o == '0)));

    p_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && !pop_i && full_o |=> err_o && $stable(sp_o) && full_o && $stable(dout_o));

    p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !push_i && empty_o |=> err_o && $stable(sp_o) && empty_o && $stable(dout_o));

    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && pop_i |=> err_o && $stable(sp_o) && $stable(dout_o));

    p_dr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !good_pop |=> $stable(dout_o));

    p_err_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (good_push || good_pop || (!push_i && !pop_i)) |=> !err_o);

    p_flags_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));
endmodule

bind reg_stack reg_stack_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .dout_o  (dout_o),
    .sp_o    (sp_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .err_o   (err_o)
);

// File: tb/reg_stack_tb_top.sv
// Bench: reg_stack_tb_top
// Sweeps fill, drain, rejected requests and pointer wrap. Expected values
// come from a behavioural model of the requirements.
module reg_stack_tb_top;
    localparam int DW    = 8;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push = 1'b0;
    logic          pop = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic [AW-1:0] sp;
    logic          full;
    logic          empty;
    logic          err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Behavioural model state
    logic [DW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_sp = '0;
    logic          m_full = 1'b0;
    logic          m_empty = 1'b1;
    logic          m_err = 1'b0;
    logic [DW-1:0] m_dr = '0;

    always #2 clk = ~clk;

    reg_stack #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .din_i(din),
        .dout_o(dout), .sp_o(sp), .full_o(full), .empty_o(empty), .err_o(err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "sp", int'(sp), int'(m_sp));
        chk(tag, "full", int'(full), int'(m_full));
        chk(tag, "empty", int'(empty), int'(m_empty));
        chk(tag, "err", int'(err), int'(m_err));
        chk(tag, "dout", int'(dout), int'(m_dr));
    endtask

    // Apply one request for one edge, advance the model, then compare
    task automatic step(input logic p, input logic q, input logic [DW-1:0] d, input string tag);
        push = p; pop = q; din = d;
        @(negedge clk);
        m_err = (p && q) || (p && m_full) || (q && m_empty);
        if (!m_err && p) begin
            m_sp = m_sp + 1'b1;
            m_mem[m_sp] = d;
            m_full = (m_sp == '0);
            m_empty = 1'b0;
        end else if (!m_err && q) begin
            m_dr = m_mem[m_sp];
            m_sp = m_sp - 1'b1;
            m_empty = (m_sp == '0);
            m_full = 1'b0;
        end
        chk_all(tag);
        push = 1'b0; pop = 1'b0;
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 37 + 11) & 8'hFF);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_all("R1 reset");

        // R3: first item goes to word 1 and returns at once
        step(1, 0, 8'hA5, "R3 first push");
        chk("R3", "sp after first push", int'(sp), 1);
        step(0, 1, 8'h00, "R3 first pop");
        chk("R3", "dout first item", int'(dout), 32'hA5);
        chk("R6", "empty after return to 0", int'(empty), 1);

        // R8: pop on empty, then R12 idle clears err
        step(0, 1, 8'h00, "R8 pop empty");
        step(0, 0, 8'h00, "R12 idle after error");
        // R9 collision while empty
        step(1, 1, 8'h33, "R9 collide empty");

        // R2/R4: fill all words
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 0, pat(i), (i == DEPTH - 1) ? "R4 last push" : "R2 push");
        end
        chk("R4", "full after fill", int'(full), 1);
        chk("R4", "sp after fill", int'(sp), 0);

        // R7: push on full is ignored
        step(1, 0, 8'hEE, "R7 push full");
        step(1, 0, 8'hEF, "R7 push full again");
        step(0, 0, 8'h00, "R12 idle");
        step(1, 1, 8'h44, "R9 collide full");

        // R5/R10: drain, first pop returns the 64th item
        for (int i = DEPTH - 1; i >= 0; i--) begin
            step(0, 1, 8'h00, "R5 pop");
            chk("R10", "LIFO order", int'(dout), int'(pat(i)));
        end
        chk("R6", "empty after drain", int'(empty), 1);

        // R11: DR holds through idles and pushes
        step(0, 0, 8'h00, "R11 hold idle");
        step(1, 0, 8'h5A, "R11 hold over push");
        chk("R11", "dout held", int'(dout), int'(pat(0)));
        step(1, 1, 8'h66, "R9 collide partial");

        // R10: interleaved pattern, wraps the pointer several times
        for (int k = 0; k < 600; k++) begin
            logic p;
            p = ((k * 7 + k / 5) % 3) != 0;
            step(p, !p, pat(k + 100), p ? "R2 mixed push" : "R10 mixed pop");
        end
        // Drain whatever is left
        while (!m_empty) step(0, 1, 8'h00, "R10 final drain");
        step(0, 1, 8'h00, "R8 pop empty end");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule